// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches one direction of an Ethernet byte stream and decides, frame by frame, whether the frame carries a PTP event message that needs a timestamp. A frame is a run of consecutive cycles with `in_valid` high. Its first byte is the first byte of the destination MAC address, so the preamble and the start delimiter are already removed. At least one idle cycle separates two frames. The classifier recognises three carriers of PTP:

- raw Ethernet
- UDP inside IPv4
- UDP inside IPv6

Each carrier can be switched on or off separately. The block also applies a programmable window to the PTP version number.

At the first byte of every frame the block pulses `sof_pulse`. A downstream timestamp unit latches its clock value on this pulse. When the frame later turns out to be an accepted event message, the block pulses `ts_commit` and presents the 16-bit sequence number on `seq_id`. The downstream unit then keeps the latched time and pairs it with that sequence number. When one-step mode is on and the message is a Sync, `insert_sync` rises together with `ts_commit`. This tells the frame rewriter to put the time into the frame in line.

A port instantiates one classifier for ingress and a second one for egress. Each instance has its own configuration inputs.

Top module: `ptp_event_classifier`

## Requirements
- R1: During and right after synchronous active-low reset, `sof_pulse`, `ts_commit` and `insert_sync` are 0 and `seq_id` is 0.
- R2: Exactly one `sof_pulse` occurs per frame. It is high for one cycle, in the cycle after the first byte is sampled.
- R3: With `cfg_l2_en` set, the block takes a frame as raw PTP when bytes 12 and 13 hold EtherType 0x88F7. The PTP header then starts at byte 14.
- R4: With `cfg_v4_en` set, the block takes a frame as IPv4 PTP when all of the following hold: EtherType is 0x0800, byte 14 is 0x45, the protocol byte 23 is 17, and the UDP destination port in bytes 36 and 37 is 319 (big-endian). The PTP header then starts at byte 42.
- R5: With `cfg_v6_en` set, the block takes a frame as IPv6 PTP when all of the following hold: EtherType is 0x86DD, the next-header byte 20 is 17, and the UDP destination port in bytes 56 and 57 is 319. The PTP header then starts at byte 62.
- R6: The block samples the three enables at byte 13. A frame whose carrier is disabled is ignored. With all three enables clear, no frame produces `ts_commit`.
- R7: The version is the low nibble of PTP header byte 1, zero-extended to 8 bits. The block accepts a frame only if `cfg_ver_min` <= version <= `cfg_ver_max`. If min is greater than max, the block accepts nothing.
- R8: The message type is the low nibble of PTP header byte 0. Only types 0 to 3 (event messages) produce `ts_commit`. For other types, no outputs change.
- R9: The sequence number is PTP header bytes 30 (high) and 31 (low). For an accepted frame, `ts_commit` is high for exactly one cycle, in the cycle after header byte 31 is sampled. In that same cycle `seq_id` takes the new value, and it then holds until the next commit.
- R10: `insert_sync` is high together with `ts_commit` only when the message type is 0 and `cfg_onestep` is set in the cycle of header byte 31. At all other times it is 0.
- R11: A frame that ends before header byte 31 produces no `ts_commit`, and the next frame is classified normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | High for every byte of a frame |
| in_byte | input | 8 | Frame byte |
| cfg_l2_en | input | 1 | Accept PTP over raw Ethernet |
| cfg_v4_en | input | 1 | Accept PTP over UDP/IPv4 |
| cfg_v6_en | input | 1 | Accept PTP over UDP/IPv6 |
| cfg_ver_min | input | 8 | Lowest accepted version |
| cfg_ver_max | input | 8 | Highest accepted version |
| cfg_onestep | input | 1 | Flag Sync messages for in-line insertion |
| sof_pulse | output | 1 | Start-of-frame timestamp latch point |
| ts_commit | output | 1 | Accepted event frame, keep latched timestamp |
| seq_id | output | 16 | Sequence number of last committed frame |
| insert_sync | output | 1 | Committed frame is a Sync to be stamped in line |

## Verification
The checker enforces, on every cycle, the following properties:
- Each strobe is a single-cycle pulse.
- Each strobe follows a sampled byte.
- `sof_pulse` and `ts_commit` never coincide.
- `insert_sync` never appears without a commit.
- `seq_id` changes only on a commit.
- A commit never occurs while the version window is inverted.

Whether a given frame should commit at all needs the directed scenarios:
- the carrier decoding
- the byte offsets of the protocol and port checks
- the enables
- the version bounds
- the message-type split
- truncation
- the exact sequence value

// File: rtl/ptpc_pkg.sv
`timescale 1ns/1ps
// Shared types and frame offsets for the PTP event classifier.
// Offsets count from the first destination-MAC byte; no VLAN tag is assumed.
package ptpc_pkg;

    typedef enum logic [1:0] {
        XP_NONE = 2'd0,
        XP_L2   = 2'd1,
        XP_V4   = 2'd2,
        XP_V6   = 2'd3
    } xport_t;

    localparam int unsigned SEQ_W        = 16;
    localparam int unsigned OFF_ETYPE_HI = 12;
    localparam int unsigned OFF_ETYPE_LO = 13;
    // IPv4 fixed-header checks
    localparam int unsigned OFF_V4_VIHL  = 14;
    localparam int unsigned OFF_V4_PROTO = 23;
    localparam int unsigned OFF_V4_DPORT = 36;
    // IPv6 fixed-header checks
    localparam int unsigned OFF_V6_NXT   = 20;
    localparam int unsigned OFF_V6_DPORT = 56;
    // Start of the PTP header per carrier
    localparam int unsigned OFF_L2_PTP   = 14;
    localparam int unsigned OFF_V4_PTP   = 42;
    localparam int unsigned OFF_V6_PTP   = 62;
    // Positions inside the PTP header
    localparam int unsigned HDR_MTYPE    = 0;
    localparam int unsigned HDR_VER      = 1;
    localparam int unsigned HDR_SEQ_HI   = 30;
    localparam int unsigned HDR_SEQ_LO   = 31;

    localparam logic [7:0] ET_PTP_HI  = 8'h88;
    localparam logic [7:0] ET_PTP_LO  = 8'hF7;
    localparam logic [7:0] ET_V4_HI   = 8'h08;
    localparam logic [7:0] ET_V4_LO   = 8'h00;
    localparam logic [7:0] ET_V6_HI   = 8'h86;
    localparam logic [7:0] ET_V6_LO   = 8'hDD;
    localparam logic [7:0] V4_VIHL    = 8'h45;
    localparam logic [7:0] PROTO_UDP  = 8'd17;
    localparam logic [7:0] PORT_EV_HI = 8'h01;
    localparam logic [7:0] PORT_EV_LO = 8'h3F;

    // Byte index of the PTP header for a given carrier (0 when none).
    function automatic logic [31:0] ptp_base(xport_t k);
        case (k)
            XP_L2:   return 32'(OFF_L2_PTP);
            XP_V4:   return 32'(OFF_V4_PTP);
            XP_V6:   return 32'(OFF_V6_PTP);
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/ptpc_frame_counter.sv
`timescale 1ns/1ps
// Byte position tracker: gives the index of the byte now on in_byte and
// pulses sof_pulse one cycle after the first byte of each frame.
// Assumes at least one idle cycle between frames; the index saturates.
module ptpc_frame_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic [CNT_W-1:0] byte_idx,
    output logic             sof_pulse
);
    logic [CNT_W-1:0] idx_q;

    assign byte_idx = idx_q;

    // Count bytes within a frame, clear in idle, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (!in_valid) begin
            idx_q <= '0;
        end else if (idx_q != '1) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Mark the first byte of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_pulse <= 1'b0;
        end else begin
            sof_pulse <= in_valid && (idx_q == '0);
        end
    end
endmodule

// File: rtl/ptpc_xport_detect.sv
`timescale 1ns/1ps
// Carrier detector: decides at the EtherType which carrier a frame uses,
// subject to the enables, then drops the frame to XP_NONE on the first
// IP/UDP header byte that does not match an event-port PTP packet.
module ptpc_xport_detect
    import ptpc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [CNT_W-1:0] byte_idx,
    input  logic             cfg_l2_en,
    input  logic             cfg_v4_en,
    input  logic             cfg_v6_en,
    output xport_t           xport
);
    logic [31:0] pos;
    logic [7:0]  et_hi_q;
    xport_t      xport_q;
    xport_t      decided;
    logic        mismatch;

    assign pos   = 32'(byte_idx);
    assign xport = xport_q;

    // Carrier chosen from the EtherType and the enables.
    always_comb begin
        decided = XP_NONE;
        if (cfg_l2_en && et_hi_q == ET_PTP_HI && in_byte == ET_PTP_LO) begin
            decided = XP_L2;
        end else if (cfg_v4_en && et_hi_q == ET_V4_HI && in_byte == ET_V4_LO) begin
            decided = XP_V4;
        end else if (cfg_v6_en && et_hi_q == ET_V6_HI && in_byte == ET_V6_LO) begin
            decided = XP_V6;
        end
    end

    // Header byte that disqualifies an IP candidate.
    always_comb begin
        mismatch = 1'b0;
        case (xport_q)
            XP_V4: begin
                if (pos == OFF_V4_VIHL      && in_byte != V4_VIHL)    mismatch = 1'b1;
                if (pos == OFF_V4_PROTO     && in_byte != PROTO_UDP)  mismatch = 1'b1;
                if (pos == OFF_V4_DPORT     && in_byte != PORT_EV_HI) mismatch = 1'b1;
                if (pos == OFF_V4_DPORT + 1 && in_byte != PORT_EV_LO) mismatch = 1'b1;
            end
            XP_V6: begin
                if (pos == OFF_V6_NXT       && in_byte != PROTO_UDP)  mismatch = 1'b1;
                if (pos == OFF_V6_DPORT     && in_byte != PORT_EV_HI) mismatch = 1'b1;
                if (pos == OFF_V6_DPORT + 1 && in_byte != PORT_EV_LO) mismatch = 1'b1;
            end
            default: mismatch = 1'b0;
        endcase
    end

    // Track the carrier state across the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xport_q <= XP_NONE;
            et_hi_q <= '0;
        end else if (in_valid) begin
            if (pos == 0) begin
                xport_q <= XP_NONE;
            end else if (pos == OFF_ETYPE_HI) begin
                et_hi_q <= in_byte;
            end else if (pos == OFF_ETYPE_LO) begin
                xport_q <= decided;
            end else if (mismatch) begin
                xport_q <= XP_NONE;
            end
        end
    end
endmodule

// File: rtl/ptpc_field_capture.sv
`timescale 1ns/1ps
// PTP header field capture: latches message type and version, assembles
// the sequence number and issues the commit and one-step flags at the
// last sequence byte when the frame passes the type and version filters.
module ptpc_field_capture
    import ptpc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [CNT_W-1:0] byte_idx,
    input  xport_t           xport,
    input  logic [7:0]       cfg_ver_min,
    input  logic [7:0]       cfg_ver_max,
    input  logic             cfg_onestep,
    output logic             ts_commit,
    output logic [SEQ_W-1:0] seq_id,
    output logic             insert_sync
);
    logic [31:0] pos;
    logic [31:0] base;
    logic [31:0] rel;
    logic        in_hdr;
    logic [3:0]  mtype_q;
    logic [3:0]  ver_q;
    logic [7:0]  seq_hi_q;
    logic [7:0]  ver_ext;
    logic        accept;

    assign pos     = 32'(byte_idx);
    assign base    = ptp_base(xport);
    assign in_hdr  = in_valid && (xport != XP_NONE) && (pos >= base);
    assign rel     = pos - base;
    assign ver_ext = {4'h0, ver_q};
    assign accept  = (mtype_q <= 4'd3) &&
                     (ver_ext >= cfg_ver_min) && (ver_ext <= cfg_ver_max);

    // Latch header fields as their bytes pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mtype_q  <= '0;
            ver_q    <= '0;
            seq_hi_q <= '0;
        end else if (in_hdr) begin
            if (rel == HDR_MTYPE)  mtype_q  <= in_byte[3:0];
            if (rel == HDR_VER)    ver_q    <= in_byte[3:0];
            if (rel == HDR_SEQ_HI) seq_hi_q <= in_byte;
        end
    end

    // Decide and publish at the low sequence byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_commit   <= 1'b0;
            insert_sync <= 1'b0;
            seq_id      <= '0;
        end else begin
            ts_commit   <= 1'b0;
            insert_sync <= 1'b0;
            if (in_hdr && rel == HDR_SEQ_LO && accept) begin
                ts_commit   <= 1'b1;
                seq_id      <= {seq_hi_q, in_byte};
                insert_sync <= cfg_onestep && (mtype_q == 4'd0);
            end
        end
    end
endmodule

// File: rtl/ptp_event_classifier.sv
`timescale 1ns/1ps
// PTP event frame classifier for one direction of a byte stream.
// Recognises PTP over raw Ethernet, UDP/IPv4 and UDP/IPv6 (each enabled
// separately), filters on a version window and event message types, and
// reports the sequence number. CNT_W must count past byte 93.
module ptp_event_classifier #(
    parameter int unsigned CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        cfg_l2_en,
    input  logic        cfg_v4_en,
    input  logic        cfg_v6_en,
    input  logic [7:0]  cfg_ver_min,
    input  logic [7:0]  cfg_ver_max,
    input  logic        cfg_onestep,
    output logic        sof_pulse,
    output logic        ts_commit,
    output logic [15:0] seq_id,
    output logic        insert_sync
);
    logic [CNT_W-1:0]        byte_idx;
    ptpc_pkg::xport_t        xport;

    ptpc_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .byte_idx  (byte_idx),
        .sof_pulse (sof_pulse)
    );

    ptpc_xport_detect #(.CNT_W(CNT_W)) u_xport (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .byte_idx  (byte_idx),
        .cfg_l2_en (cfg_l2_en),
        .cfg_v4_en (cfg_v4_en),
        .cfg_v6_en (cfg_v6_en),
        .xport     (xport)
    );

    ptpc_field_capture #(.CNT_W(CNT_W)) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .byte_idx    (byte_idx),
        .xport       (xport),
        .cfg_ver_min (cfg_ver_min),
        .cfg_ver_max (cfg_ver_max),
        .cfg_onestep (cfg_onestep),
        .ts_commit   (ts_commit),
        .seq_id      (seq_id),
        .insert_sync (insert_sync)
    );
endmodule

// File: rtl/ptpc_checker.sv
`timescale 1ns/1ps
// Cycle properties of the classifier outputs, bound to the top module.
module ptpc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  cfg_ver_min,
    input logic [7:0]  cfg_ver_max,
    input logic        sof_pulse,
    input logic        ts_commit,
    input logic [15:0] seq_id,
    input logic        insert_sync
);
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse); // R2
    AST_SOF_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> $past(in_valid)); // R2
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_commit |=> !ts_commit); // R9
    AST_COMMIT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_commit |-> $past(in_valid)); // R11
    AST_COMMIT_NOT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        ts_commit |-> !sof_pulse); // R9
    AST_SEQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_commit |-> $stable(seq_id)); // R9
    AST_WINDOW_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        ts_commit |-> ($past(cfg_ver_min) <= $past(cfg_ver_max))); // R7
    AST_INSERT_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        insert_sync |-> ts_commit); // R10
endmodule

bind ptp_event_classifier ptpc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .cfg_ver_min (cfg_ver_min),
    .cfg_ver_max (cfg_ver_max),
    .sof_pulse   (sof_pulse),
    .ts_commit   (ts_commit),
    .seq_id      (seq_id),
    .insert_sync (insert_sync)
);

// File: tb/ptp_event_classifier_bench.sv
`timescale 1ns/1ps
module ptp_event_classifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        cfg_l2_en = 1'b0, cfg_v4_en = 1'b0, cfg_v6_en = 1'b0;
    logic [7:0]  cfg_ver_min = '0, cfg_ver_max = '0;
    logic        cfg_onestep = 1'b0;
    logic        sof_pulse, ts_commit, insert_sync;
    logic [15:0] seq_id;

    int checks = 0, fails = 0;
    int commits = 0, sofs = 0;
    int last_seq = 0, last_ins = 0;
    logic [7:0] frm [0:127];
    int flen = 0;

    always #2.5 clk = ~clk;

    ptp_event_classifier u_ptp_event_classifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_l2_en(cfg_l2_en), .cfg_v4_en(cfg_v4_en), .cfg_v6_en(cfg_v6_en),
        .cfg_ver_min(cfg_ver_min), .cfg_ver_max(cfg_ver_max),
        .cfg_onestep(cfg_onestep), .sof_pulse(sof_pulse),
        .ts_commit(ts_commit), .seq_id(seq_id), .insert_sync(insert_sync)
    );

    // Output monitor, sampled 1 ns after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (rst_n && ts_commit) begin
            commits++;
            last_seq = int'(seq_id);
            last_ins = int'(insert_sync);
        end
        if (rst_n && sof_pulse) sofs++;
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(bit l2, bit v4, bit v6, int vmin, int vmax, bit os);
        @(negedge clk);
        cfg_l2_en = l2; cfg_v4_en = v4; cfg_v6_en = v6;
        cfg_ver_min = 8'(vmin); cfg_ver_max = 8'(vmax); cfg_onestep = os;
    endtask

    // kind: 0 raw Ethernet, 1 IPv4, 2 IPv6
    task automatic build(int kind, int mtype, int verb, int seq);
        int base;
        for (int i = 0; i < 128; i++) frm[i] = 8'(i * 7);
        base = (kind == 0) ? 14 : (kind == 1) ? 42 : 62;
        case (kind)
            0: begin frm[12] = 8'h88; frm[13] = 8'hF7; end
            1: begin
                frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45;
                frm[23] = 8'd17; frm[36] = 8'h01; frm[37] = 8'h3F;
            end
            default: begin
                frm[12] = 8'h86; frm[13] = 8'hDD; frm[14] = 8'h60;
                frm[20] = 8'd17; frm[56] = 8'h01; frm[57] = 8'h3F;
            end
        endcase
        frm[base]      = 8'(mtype);
        frm[base + 1]  = 8'(verb);
        frm[base + 30] = 8'(seq >> 8);
        frm[base + 31] = 8'(seq);
        flen = base + 44;
    endtask

    task automatic send(int gap);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = frm[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = '0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic expect_frame(string req, int ncommit, int seq, int ins);
        int c0 = commits;
        int s0 = sofs;
        int q0 = last_seq;
        send(3);
        check(req, "commit count", commits - c0, ncommit);
        check("R2", "sof count", sofs - s0, 1);
        if (ncommit == 1) begin
            check(req, "seq_id", last_seq, seq);
            check("R10", "insert_sync", last_ins, ins);
        end else begin
            check(req, "seq_id held", int'(seq_id), q0);
        end
    endtask

    task automatic t_reset;
        check("R1", "sof_pulse", int'(sof_pulse), 0);
        check("R1", "ts_commit", int'(ts_commit), 0);
        check("R1", "seq_id", int'(seq_id), 0);
        check("R1", "insert_sync", int'(insert_sync), 0);
    endtask

    task automatic t_raw_eth;
        set_cfg(1, 1, 1, 2, 2, 0);
        build(0, 0, 8'h02, 16'h1234); expect_frame("R3", 1, 16'h1234, 0);
        build(0, 0, 8'h02, 16'hFFFE); expect_frame("R9", 1, 16'hFFFE, 0);
    endtask

    task automatic t_onestep;
        set_cfg(1, 1, 1, 2, 2, 1);
        build(0, 0, 8'h02, 16'h0101); expect_frame("R10", 1, 16'h0101, 1);
        build(0, 1, 8'h02, 16'h0202); expect_frame("R10", 1, 16'h0202, 0);
        build(0, 3, 8'h02, 16'h0303); expect_frame("R8", 1, 16'h0303, 0);
    endtask

    task automatic t_general;
        set_cfg(1, 1, 1, 2, 2, 1);
        build(0, 8, 8'h02, 16'h0808); expect_frame("R8", 0, 0, 0);
        build(0, 11, 8'h02, 16'h0B0B); expect_frame("R8", 0, 0, 0);
        build(0, 4, 8'h02, 16'h0404); expect_frame("R8", 0, 0, 0);
    endtask

    task automatic t_ipv4;
        set_cfg(1, 1, 1, 2, 2, 0);
        build(1, 0, 8'h02, 16'hBEEF); expect_frame("R4", 1, 16'hBEEF, 0);
        build(1, 0, 8'h02, 16'h1111); frm[37] = 8'h40; expect_frame("R4", 0, 0, 0);
        build(1, 0, 8'h02, 16'h2222); frm[23] = 8'd6;  expect_frame("R4", 0, 0, 0);
        build(1, 0, 8'h02, 16'h3333); frm[14] = 8'h46; expect_frame("R4", 0, 0, 0);
    endtask

    task automatic t_ipv6;
        set_cfg(1, 1, 1, 2, 2, 1);
        build(2, 0, 8'h02, 16'h0F0F); expect_frame("R5", 1, 16'h0F0F, 1);
        build(2, 0, 8'h02, 16'h4444); frm[20] = 8'd6;  expect_frame("R5", 0, 0, 0);
        build(2, 0, 8'h02, 16'h5555); frm[56] = 8'h02; expect_frame("R5", 0, 0, 0);
    endtask

    task automatic t_enables;
        set_cfg(0, 1, 0, 2, 2, 0);
        build(0, 0, 8'h02, 16'hA001); expect_frame("R6", 0, 0, 0);
        build(2, 0, 8'h02, 16'hA002); expect_frame("R6", 0, 0, 0);
        build(1, 0, 8'h02, 16'hA003); expect_frame("R6", 1, 16'hA003, 0);
        set_cfg(0, 0, 0, 0, 15, 0);
        build(0, 0, 8'h02, 16'hA004); expect_frame("R6", 0, 0, 0);
        build(1, 0, 8'h02, 16'hA005); expect_frame("R6", 0, 0, 0);
        build(2, 0, 8'h02, 16'hA006); expect_frame("R6", 0, 0, 0);
    endtask

    task automatic t_version;
        set_cfg(1, 1, 1, 2, 2, 0);
        build(0, 0, 8'h12, 16'hC001); expect_frame("R7", 1, 16'hC001, 0);
        set_cfg(1, 1, 1, 3, 4, 0);
        build(0, 0, 8'h02, 16'hC002); expect_frame("R7", 0, 0, 0);
        build(0, 0, 8'h03, 16'hC003); expect_frame("R7", 1, 16'hC003, 0);
        build(0, 0, 8'h04, 16'hC004); expect_frame("R7", 1, 16'hC004, 0);
        build(0, 0, 8'h05, 16'hC005); expect_frame("R7", 0, 0, 0);
        set_cfg(1, 1, 1, 5, 3, 0);
        build(0, 0, 8'h04, 16'hC006); expect_frame("R7", 0, 0, 0);
    endtask

    task automatic t_truncated;
        set_cfg(1, 1, 1, 2, 2, 0);
        build(0, 0, 8'h02, 16'hD001); flen = 14 + 31;
        expect_frame("R11", 0, 0, 0);
        build(0, 0, 8'h02, 16'hD002); expect_frame("R11", 1, 16'hD002, 0);
    endtask

    task automatic t_back_to_back;
        int c0;
        set_cfg(1, 1, 1, 2, 2, 0);
        c0 = commits;
        build(0, 0, 8'h02, 16'hE001); send(1);
        build(1, 1, 8'h02, 16'hE002); send(3);
        check("R9", "back-to-back commits", commits - c0, 2);
        check("R9", "back-to-back last seq", last_seq, 16'hE002);
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_raw_eth;
        t_onestep;
        t_general;
        t_ipv4;
        t_ipv6;
        t_enables;
        t_version;
        t_truncated;
        t_back_to_back;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule